// File: doc/BRIEF.md
# Periodic Tick and Interrupt Generator

This block turns a free-running reference clock into two periodic enables, one at a hundredth of a second and one at a tenth of a second. It also keeps the interrupt status, the interrupt mask and a level interrupt line for the processor. Software sets the nominal frequency of the reference clock with a two-bit selector in the command register. A phase accumulator then adds the tick rate once per clock and subtracts the selected frequency each time the sum reaches it. The average tick rate is therefore exact for every selector value, even when the frequency is not a whole multiple of the rate. The hundredth-second enable goes straight to a time-of-day counter; the tenth-second enable is every tenth of those pulses.

A byte-wide register port reaches two addresses. The interrupt address is written to set the mask and read to collect the status. Every read of it clears the whole status byte, the summary pending bit included. The command address holds the frequency selector and the interrupt enable. The interrupt line is asserted only while an unmasked status bit is set and the enable bit is on.

Top module: `pirq_ticker`

## Requirements
- R1: Reset clears the mask, the status byte, the pending bit, the frequency selector and the interrupt enable. After reset, `irq` and both ticks are low and a read of address 16 returns 0x00.
- R2: Command bits 1:0 select the reference frequency: 00 = `FREQ_0`, 01 = `FREQ_1`, 10 = `FREQ_2`, 11 = `FREQ_3`. The defaults are 32768, 1048576, 2097152 and 4194304 Hz. After the accumulator restarts, exactly floor(N*`TICK_HZ`/F) one-cycle `tick_hsec` pulses appear in the N cycles that follow.
- R3: `tick_tsec` pulses in the same cycle as every `TSEC_DIV`-th `tick_hsec` pulse, counted from a restart.
- R4: A write to address 17 whose bits 1:0 differ from the stored selector restarts the accumulator and the tenth counter at that clock edge. A write that keeps the selector unchanged does not disturb the tick phase.
- R5: Status bit 1 (hundredth) and status bit 2 (tenth) are set at the edge after their tick pulse, whether or not they are masked.
- R6: A write to address 16 loads the mask from data bits 6:0. Data bit 7 is ignored, so writing 0x80 leaves every source masked off.
- R7: Status bit 7 (pending) is set when the status ANDed with the mask is nonzero. It stays set until address 16 is read, even if the mask is later cleared.
- R8: A read of address 16 presents {pending, status} on `rd_data` one cycle later and clears the whole register at that edge. A tick in the cycle of the read is kept in the cleared register.
- R9: `irq` is high in any cycle in which (status AND mask) is nonzero and command bit 4 (interrupt enable) is 1. It follows register changes one cycle after the edge that makes them.
- R10: Command bit 5 (test mode) is not supported and is discarded, so writing 0x33 acts exactly like writing 0x13.
- R11: Reads of address 17 and of any address other than 16 return 0xFF. Writes to addresses other than 16 and 17 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at the selected nominal frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |
| tick_hsec | output | 1 | Hundredth-second enable pulse |
| tick_tsec | output | 1 | Tenth-second enable pulse |

## Verification
A restarting command write at edge 0 clears the accumulator. The first `tick_hsec` pulse is then visible just after the edge at which the running sum first reaches F. The matching status bit and `irq` follow one edge later, and read data arrives one edge after its strobe. The bench keeps a cycle count relative to the restart edge, issues every access at a chosen edge number and samples on the falling clock edge after the edge at which each result is due. It places one read in the exact cycle of a tick so that the kept tick can be seen. Rate checks count pulses over a window that starts at a restart, so the expected totals are exact floors and need no tolerance.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned IRQ_ADDR  = 16;
   localparam int unsigned CMD_ADDR  = 17;
   localparam int unsigned SRC_W     = 7;
   localparam int unsigned PEND_BIT  = 7;
   localparam int unsigned HSEC_BIT  = 1;
   localparam int unsigned TSEC_BIT  = 2;
   localparam int unsigned IEN_BIT   = 4;
   localparam logic [7:0]  UNDEF_RD  = 8'hFF;
   typedef logic [1:0] freq_sel_t;
endpackage

// File: rtl/pirq_phase_acc.sv
module pirq_phase_acc
   import pirq_pkg::*;
#(
   parameter int unsigned FREQ_0  = 32768,
   parameter int unsigned FREQ_1  = 1048576,
   parameter int unsigned FREQ_2  = 2097152,
   parameter int unsigned FREQ_3  = 4194304,
   parameter int unsigned TICK_HZ = 100
) (
   input  logic      clk,
   input  logic      rst_n,
   input  freq_sel_t sel_i,
   input  logic      clr_i,
   output logic      tick_o
);
   localparam int unsigned F01   = (FREQ_0 > FREQ_1) ? FREQ_0 : FREQ_1;
   localparam int unsigned F23   = (FREQ_2 > FREQ_3) ? FREQ_2 : FREQ_3;
   localparam int unsigned FMAX  = (F01 > F23) ? F01 : F23;
   localparam int unsigned ACC_W = $clog2(FMAX + TICK_HZ + 1);

   generate
      if (TICK_HZ < 1 || TICK_HZ >= FREQ_0 || TICK_HZ >= FREQ_1 ||
          TICK_HZ >= FREQ_2 || TICK_HZ >= FREQ_3) begin : g_bad_rate
         $error("pirq_phase_acc: TICK_HZ must be nonzero and below every frequency");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q, sum, freq_cur;
   logic             tick_q;

   always_comb begin
      case (sel_i)
         2'd0:    freq_cur = ACC_W'(FREQ_0);
         2'd1:    freq_cur = ACC_W'(FREQ_1);
         2'd2:    freq_cur = ACC_W'(FREQ_2);
         default: freq_cur = ACC_W'(FREQ_3);
      endcase
      sum = acc_q + ACC_W'(TICK_HZ);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (sum >= freq_cur) begin
         acc_q  <= sum - freq_cur;
         tick_q <= 1'b1;
      end else begin
         acc_q  <= sum;
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;

   a_r2_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < freq_cur);
   a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_q == '0 && !tick_q));
endmodule

// File: rtl/pirq_decim.sv
module pirq_decim #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic hsec_i,
   output logic tsec_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("pirq_decim: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ clr_i;
         assign tsec_o = hsec_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          last;
         assign last = (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || clr_i)   cnt_q <= '0;
            else if (hsec_i)       cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
         assign tsec_o = hsec_i & last;

         a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q < CW'(DIV));
         a_r3_wrap_after_tenth: assert property (@(posedge clk) disable iff (!rst_n)
            (tsec_o && !clr_i) |=> (cnt_q == '0));
      end
   endgenerate
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wr_data,
   input  logic              hsec_i,
   input  logic              tsec_i,
   output logic [7:0]        rd_data_o,
   output logic              irq_o,
   output freq_sel_t         sel_o,
   output logic              restart_o
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("pirq_regs: ADDR_W must reach address 17");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_ADDR);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_ADDR);

   logic [SRC_W-1:0] mask_q, mask_d, status_q, status_d, tick_bits;
   logic             pend_q, pend_d, ien_q;
   freq_sel_t        sel_q;
   logic [7:0]       rd_q;
   logic             wr_irq, wr_cmd, rd_irq;
   logic             unused_bits;

   assign unused_bits = wr_data[7] ^ wr_data[5] ^ wr_data[3] ^ wr_data[2];

   assign wr_irq = wr_en && (addr == A_IRQ);
   assign wr_cmd = wr_en && (addr == A_CMD);
   assign rd_irq = rd_en && (addr == A_IRQ);

   always_comb begin
      tick_bits           = '0;
      tick_bits[HSEC_BIT] = hsec_i;
      tick_bits[TSEC_BIT] = tsec_i;
      mask_d   = wr_irq ? wr_data[SRC_W-1:0] : mask_q;
      status_d = (rd_irq ? '0 : status_q) | tick_bits;
      pend_d   = (rd_irq ? 1'b0 : pend_q) | (|(status_d & mask_d));
   end

   assign restart_o = wr_cmd && (wr_data[1:0] != sel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '0;
         status_q <= '0;
         pend_q   <= 1'b0;
         ien_q    <= 1'b0;
         sel_q    <= '0;
         rd_q     <= '0;
      end else begin
         mask_q   <= mask_d;
         status_q <= status_d;
         pend_q   <= pend_d;
         if (wr_cmd) begin
            sel_q <= wr_data[1:0];
            ien_q <= wr_data[IEN_BIT];
         end
         if (rd_en) rd_q <= rd_irq ? {pend_q, status_q} : UNDEF_RD;
      end
   end

   assign rd_data_o = rd_q;
   assign sel_o     = sel_q;
   assign irq_o     = ien_q & (|(status_q & mask_q));

   a_r5_hsec_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      hsec_i |=> status_q[HSEC_BIT]);
   a_r5_tsec_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      tsec_i |=> status_q[TSEC_BIT]);
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_irq && !hsec_i && !tsec_i) |=> (status_q == '0 && !pend_q));
   a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rd_irq) |=> pend_q);
   a_r9_irq_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend_q);
endmodule

// File: rtl/pirq_ticker.sv
module pirq_ticker
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned FREQ_0   = 32768,
   parameter int unsigned FREQ_1   = 1048576,
   parameter int unsigned FREQ_2   = 2097152,
   parameter int unsigned FREQ_3   = 4194304,
   parameter int unsigned TICK_HZ  = 100,
   parameter int unsigned TSEC_DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              irq,
   output logic              tick_hsec,
   output logic              tick_tsec
);
   freq_sel_t sel;
   logic      restart;

   pirq_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .hsec_i(tick_hsec), .tsec_i(tick_tsec),
      .rd_data_o(rd_data), .irq_o(irq), .sel_o(sel), .restart_o(restart)
   );

   pirq_phase_acc #(
      .FREQ_0(FREQ_0), .FREQ_1(FREQ_1), .FREQ_2(FREQ_2), .FREQ_3(FREQ_3),
      .TICK_HZ(TICK_HZ)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .clr_i(restart), .tick_o(tick_hsec)
   );

   pirq_decim #(.DIV(TSEC_DIV)) u_decim (
      .clk(clk), .rst_n(rst_n), .clr_i(restart), .hsec_i(tick_hsec), .tsec_o(tick_tsec)
   );

   a_r3_tsec_with_hsec: assert property (@(posedge clk) disable iff (!rst_n)
      tick_tsec |-> tick_hsec);
endmodule

// File: tb/pirq_ticker_tb.sv
module pirq_ticker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq, tick_hsec, tick_tsec;

   int checks = 0, fails = 0, cyc = 0, t0 = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pirq_ticker #(
      .ADDR_W(5), .FREQ_0(250), .FREQ_1(330), .FREQ_2(400), .FREQ_3(1000),
      .TICK_HZ(100), .TSEC_DIV(10)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
      .tick_hsec(tick_hsec), .tick_tsec(tick_tsec)
   );

   // {sel, window, expected hundredth pulses, expected tenth pulses}
   localparam logic [47:0] VEC [4] = '{
      {2'd1, 16'd990,  16'd300, 14'd30},
      {2'd2, 16'd1000, 16'd250, 14'd25},
      {2'd3, 16'd1000, 16'd100, 14'd10},
      {2'd0, 16'd1000, 16'd400, 14'd40}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_until(input int n);
      while (cyc - t0 < n) @(negedge clk);
   endtask

   task automatic restart_cmd(input logic [7:0] d);
      @(negedge clk);
      addr = 5'd17; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      t0 = cyc;
      wr_en = 1'b0;
   endtask

   task automatic wr_at(input int n, input logic [4:0] a, input logic [7:0] d);
      wait_until(n - 1);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_at(input int n, input logic [4:0] a, output logic [7:0] d);
      wait_until(n - 1);
      addr = a; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      int nh, nt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd_at(cyc - t0 + 1, 5'd16, d);
      check("R1 status after reset", d, 8'h00);
      check("R1 irq after reset", irq, 0);
      check("R1 tick after reset", tick_hsec, 0);

      // R2 R3: rate table, each entry restarts the accumulator
      for (int v = 0; v < 4; v++) begin
         restart_cmd({6'b0, VEC[v][47:46]});
         nh = 0; nt = 0;
         for (int i = 0; i < int'(VEC[v][45:30]); i++) begin
            @(negedge clk);
            nh += int'(tick_hsec);
            nt += int'(tick_tsec);
         end
         check("R2 hundredth pulse count", nh, int'(VEC[v][29:14]));
         check("R3 tenth pulse count", nt, int'(VEC[v][13:0]));
      end

      // directed sequence on FREQ_3 (one hundredth tick every 10 cycles)
      restart_cmd(8'h03);
      rd_at(2, 5'd16, d);
      wr_at(4, 5'd16, 8'h02);
      wr_at(6, 5'd17, 8'h13);
      wait_until(7);  check("R9 irq low with nothing pending", irq, 0);
      wait_until(10); check("R2 first tick edge", tick_hsec, 1);
      check("R5 irq not before status", irq, 0);
      wait_until(11); check("R9 irq follows masked status", irq, 1);
      rd_at(15, 5'd16, d);
      check("R7 pending with masked source", d, 8'h82);
      check("R8 irq drops after read", irq, 0);
      rd_at(21, 5'd16, d);
      check("R8 read returns cleared value", d, 8'h00);
      check("R8 tick during read kept", irq, 1);
      rd_at(25, 5'd16, d);
      check("R8 kept tick visible", d, 8'h82);
      wr_at(28, 5'd17, 8'h03);
      check("R9 enable off gates irq", irq, 0);
      wait_until(32); check("R9 irq stays low with enable off", irq, 0);
      wait_until(38); check("R4 no restart on same selector", tick_hsec, 0);
      wait_until(40); check("R4 tick phase preserved", tick_hsec, 1);
      wr_at(45, 5'd17, 8'h33);
      check("R10 test bit ignored, enable taken", irq, 1);
      wr_at(48, 5'd16, 8'h80);
      check("R6 bit 7 of mask write dropped", irq, 0);
      rd_at(52, 5'd16, d);
      check("R7 pending sticky after mask cleared", d, 8'h82);
      wait_until(99); check("R6 no irq with empty mask", irq, 0);
      rd_at(105, 5'd16, d);
      check("R5 unmasked sources still set", d, 8'h06);
      wr_at(108, 5'd3, 8'h7F);
      wait_until(122); check("R11 stray write leaves mask", irq, 0);
      rd_at(125, 5'd16, d);
      check("R11 stray write no pending", d, 8'h02);
      rd_at(127, 5'd17, d);
      check("R11 command read", d, 8'hFF);
      rd_at(129, 5'd5, d);
      check("R11 undefined read", d, 8'hFF);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule